// File: doc/BRIEF.md
# Boot Address Remap and Pause Controller

This block sits on the address path between a CPU bus master and the downstream system bus. After reset it can run in a boot map. In the boot map, a fixed set of address windows is redirected to other bases, for example so that low addresses reach a boot ROM. Software leaves the boot map by writing one control register. From then on the block runs in a flat map and every address passes through untouched. Only a reset brings the boot map back.

Each window has three values, all driven from strap inputs: an inclusive start, an inclusive end (normally base plus size minus one) and a relocation target, plus an enable bit. A parameter fixes the number of windows. Translation is purely combinational, so forwarding adds no cycle. When windows overlap, the one with the lowest index takes the access.

A small word register port serves four purposes:
- It returns an identification constant.
- It reports and clears a power-on reset flag.
- It leaves the boot map when software writes to it.
- It pauses the CPU. A pause write raises a halt output that stays high until a wake pulse arrives.

Top module: `remap_pause_ctrl`

## Requirements
- R1: While the boot map is active and the CPU address lies in an enabled window (start <= addr <= end, both ends included), `sys_addr` equals that window's target plus (addr - start), in the same cycle.
- R2: While the flat map is active, or when no enabled window matches, `sys_addr` equals `cpu_addr`.
- R3: When several enabled windows match, the window with the lowest index decides the translation.
- R4: A window whose enable bit is 0 never matches.
- R5: During reset the map state is loaded from `boot_strap`: 1 selects the boot map and 0 selects the flat map.
- R6: A register write to byte offset 0x20, with any data, selects the flat map from the next clock. No register access can reselect the boot map; only reset can.
- R7: A read of offset 0x00 returns the `ID_VALUE` parameter.
- R8: Reset sets the power-on flag. A read of offset 0x30 returns the flag in bit 0, with all other bits zero.
- R9: A write to offset 0x34 with data bit 0 = 1 clears the power-on flag. The same write with bit 0 = 0 leaves the flag unchanged.
- R10: A write to offset 0x08 raises `halt` at the next clock. `halt` stays high until `wake` is sampled high, and it then falls at that clock edge. If a pause write and `wake` arrive in the same cycle, `halt` stays high.
- R11: `reg_rdata` shows the read value in the cycle after the read request and is zero in any cycle without a read request. Reset clears it and `halt` to 0.
- R12: Every offset other than 0x00 and 0x30 reads as zero, including the write-only offsets 0x08, 0x20 and 0x34 and any offset whose low two bits are not zero. Writes to offsets other than 0x08, 0x20 and 0x34 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_strap | input | 1 | Map selected during reset (1 = boot map) |
| win_en | input | NUM_WIN | Per-window enable |
| win_start | input | NUM_WIN x ADDR_W | Inclusive window start addresses |
| win_end | input | NUM_WIN x ADDR_W | Inclusive window end addresses |
| win_target | input | NUM_WIN x ADDR_W | Relocation bases |
| cpu_addr | input | ADDR_W | Address from the CPU |
| sys_addr | output | ADDR_W | Address forwarded downstream |
| reg_sel | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| wake | input | 1 | Pulse that releases halt |
| halt | output | 1 | Halt request to the CPU |

## Verification
The bench builds the block with three windows of 32-bit addresses and a 32-bit data port. Window 0 and window 1 overlap, so the priority rule is exercised. Both inclusive edges of both windows are tested, along with the first address past window 1. The third window's enable is switched at run time, which makes the disabled-window case visible at the address output. Running both strap values through reset shows that the power-up map choice and the one-way exit from the boot map behave as required.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int REG_AW = 6;
  typedef logic [REG_AW-1:0] reg_off_t;

  localparam reg_off_t OFF_IDENT  = 6'h00;
  localparam reg_off_t OFF_PAUSE  = 6'h08;
  localparam reg_off_t OFF_LEAVE  = 6'h20;
  localparam reg_off_t OFF_PORSTS = 6'h30;
  localparam reg_off_t OFF_PORCLR = 6'h34;
endpackage

// File: rtl/remap_win_match.sv
module remap_win_match #(
  parameter int ADDR_W = 32
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // Both bounds are inclusive.
  always_comb begin
    hit = en && (addr >= lo) && (addr <= hi);
  end
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 3
) (
  input  logic                            boot_active,
  input  logic [NUM_WIN-1:0]              hits,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  lo,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  target,
  input  logic [ADDR_W-1:0]               addr_in,
  output logic [ADDR_W-1:0]               addr_out
);
  logic              found;
  logic [ADDR_W-1:0] reloc;

  // Walk from the highest index down so the lowest matching window wins.
  always_comb begin
    found = 1'b0;
    reloc = addr_in;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) begin
        found = 1'b1;
        reloc = target[i] + (addr_in - lo[i]);
      end
    end
    addr_out = (boot_active && found) ? reloc : addr_in;
  end
endmodule

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h5250_0A01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_strap,
  input  logic              sel,
  input  logic              we,
  input  reg_off_t          off,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wake,
  output logic [DATA_W-1:0] rdata,
  output logic              halt,
  output logic              boot_active,
  output logic              por_flag
);
  logic              wr_pause, wr_leave, wr_porclr, rd_req;
  logic [DATA_W-1:0] rd_val;
  logic              boot_q, por_q, halt_q;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    wr_pause  = sel && we && (off == OFF_PAUSE);
    wr_leave  = sel && we && (off == OFF_LEAVE);
    wr_porclr = sel && we && (off == OFF_PORCLR) && wdata[0];
    rd_req    = sel && !we;
    case (off)
      OFF_IDENT:  rd_val = DATA_W'(ID_VALUE);
      OFF_PORSTS: rd_val = DATA_W'(por_q);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_q  <= boot_strap;
      por_q   <= 1'b1;
      halt_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_leave)  boot_q <= 1'b0;
      if (wr_porclr) por_q  <= 1'b0;
      if (wr_pause)  halt_q <= 1'b1;
      else if (wake) halt_q <= 1'b0;
      rdata_q <= rd_req ? rd_val : '0;
    end
  end

  assign rdata       = rdata_q;
  assign halt        = halt_q;
  assign boot_active = boot_q;
  assign por_flag    = por_q;
endmodule

// File: rtl/remap_pause_ctrl.sv
module remap_pause_ctrl
  import remap_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          NUM_WIN  = 3,
  parameter logic [31:0] ID_VALUE = 32'h5250_0A01
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           boot_strap,
  input  logic [NUM_WIN-1:0]             win_en,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] win_start,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] win_end,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] win_target,
  input  logic [ADDR_W-1:0]              cpu_addr,
  output logic [ADDR_W-1:0]              sys_addr,
  input  logic                           reg_sel,
  input  logic                           reg_we,
  input  logic [REG_AW-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  input  logic                           wake,
  output logic                           halt
);
  logic [NUM_WIN-1:0] hits;
  logic               boot_q;
  logic               por_q;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    remap_win_match #(.ADDR_W(ADDR_W)) u_match (
      .en   (win_en[g]),
      .lo   (win_start[g]),
      .hi   (win_end[g]),
      .addr (cpu_addr),
      .hit  (hits[g])
    );
  end

  remap_xlate #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_xlate (
    .boot_active (boot_q),
    .hits        (hits),
    .lo          (win_start),
    .target      (win_target),
    .addr_in     (cpu_addr),
    .addr_out    (sys_addr)
  );

  remap_regs #(.DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .boot_strap  (boot_strap),
    .sel         (reg_sel),
    .we          (reg_we),
    .off         (reg_addr),
    .wdata       (reg_wdata),
    .wake        (wake),
    .rdata       (reg_rdata),
    .halt        (halt),
    .boot_active (boot_q),
    .por_flag    (por_q)
  );
endmodule

// File: rtl/remap_pause_chk.sv
module remap_pause_chk
  import remap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [ADDR_W-1:0] sys_addr,
  input logic              boot_active,
  input logic              por_flag,
  input logic              halt,
  input logic              wake,
  input logic              reg_sel,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata
);
  // R2
  flat_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !boot_active |-> (sys_addr == cpu_addr));

  // R6
  boot_oneway_chk: assert property (@(posedge clk) disable iff (rst)
    !boot_active |=> !boot_active);

  // R6
  leave_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && reg_we && reg_addr == OFF_LEAVE) |=> !boot_active);

  // R10
  halt_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halt) |-> $past(reg_sel && reg_we && reg_addr == OFF_PAUSE));

  // R10
  halt_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(halt) |-> $past(wake));

  // R8
  por_set_chk: assert property (@(posedge clk)
    rst |=> por_flag);

  // R9
  por_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(por_flag) |-> $past(reg_sel && reg_we && reg_addr == OFF_PORCLR && reg_wdata[0]));
endmodule

bind remap_pause_ctrl remap_pause_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_addr    (cpu_addr),
  .sys_addr    (sys_addr),
  .boot_active (boot_q),
  .por_flag    (por_q),
  .halt        (halt),
  .wake        (wake),
  .reg_sel     (reg_sel),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata)
);

// File: tb/tb_remap_pause_ctrl.sv
`timescale 1ns/1ps
module tb_remap_pause_ctrl;
  localparam int          AW  = 32;
  localparam int          DW  = 32;
  localparam int          NW  = 3;
  localparam logic [31:0] IDV = 32'h5250_0A01;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   boot_strap = 1'b1;
  logic [NW-1:0]          win_en;
  logic [NW-1:0][AW-1:0]  win_start, win_end, win_target;
  logic [AW-1:0]          cpu_addr = '0;
  logic [AW-1:0]          sys_addr;
  logic                   reg_sel = 1'b0, reg_we = 1'b0;
  logic [5:0]             reg_addr = '0;
  logic [DW-1:0]          reg_wdata = '0;
  logic [DW-1:0]          reg_rdata;
  logic                   wake = 1'b0;
  logic                   halt;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  remap_pause_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_WIN(NW), .ID_VALUE(IDV)) dut (
    .clk(clk), .rst(rst), .boot_strap(boot_strap),
    .win_en(win_en), .win_start(win_start), .win_end(win_end), .win_target(win_target),
    .cpu_addr(cpu_addr), .sys_addr(sys_addr),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wake(wake), .halt(halt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1'b1; boot_strap = strap;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic reg_wr(input logic [5:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = off; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] off, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = off;
    @(negedge clk);
    reg_sel = 1'b0;
    d = reg_rdata;
  endtask

  task automatic xl(input string req, input logic [31:0] a, input logic [31:0] exp);
    cpu_addr = a;
    #1;
    check(req, sys_addr, exp);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset(1'b1);
    check("R11 halt after reset", {31'b0, halt}, 32'h0);
    check("R11 rdata after reset", reg_rdata, 32'h0);
    reg_rd(6'h00, d); check("R7 identification", d, IDV);
    reg_rd(6'h30, d); check("R8 power-on flag set", d, 32'h1);
    @(negedge clk);
    check("R11 rdata zero without read", reg_rdata, 32'h0);
  endtask

  task automatic t_translate();
    xl("R1 inside window 0", 32'h0000_0010, 32'h0400_0010);
    xl("R1 window 0 start inclusive", 32'h0000_0000, 32'h0400_0000);
    xl("R1 window 0 end inclusive", 32'h0000_FFFF, 32'h0400_FFFF);
    xl("R3 overlap picks window 0", 32'h0000_8000, 32'h0400_8000);
    xl("R1 window 1 only", 32'h0001_0000, 32'h0800_8000);
    xl("R1 window 1 end inclusive", 32'h0001_7FFF, 32'h0800_FFFF);
    xl("R2 past window 1 end", 32'h0001_8000, 32'h0001_8000);
    xl("R4 disabled window 2", 32'h1000_0010, 32'h1000_0010);
    win_en[2] = 1'b1;
    xl("R1 window 2 enabled", 32'h1000_0010, 32'h3000_0010);
    win_en[2] = 1'b0;
  endtask

  task automatic t_por_clear();
    logic [31:0] d;
    reg_wr(6'h34, 32'hFFFF_FFFE);
    reg_rd(6'h30, d); check("R9 clear with bit0=0 ignored", d, 32'h1);
    reg_wr(6'h34, 32'h1);
    reg_rd(6'h30, d); check("R9 clear with bit0=1", d, 32'h0);
  endtask

  task automatic t_undefined();
    logic [31:0] d;
    reg_wr(6'h04, 32'hFFFF_FFFF);
    reg_wr(6'h21, 32'h1);
    reg_wr(6'h09, 32'h1);
    check("R12 bad offsets no halt", {31'b0, halt}, 32'h0);
    xl("R12 bad offsets keep boot map", 32'h0000_0010, 32'h0400_0010);
    reg_rd(6'h04, d); check("R12 read 0x04", d, 32'h0);
    reg_rd(6'h08, d); check("R12 read 0x08", d, 32'h0);
    reg_rd(6'h20, d); check("R12 read 0x20", d, 32'h0);
    reg_rd(6'h01, d); check("R12 unaligned read", d, 32'h0);
    reg_rd(6'h3C, d); check("R12 read 0x3C", d, 32'h0);
  endtask

  task automatic t_halt();
    reg_wr(6'h08, 32'h0);
    check("R10 halt after pause write", {31'b0, halt}, 32'h1);
    repeat (3) @(negedge clk);
    check("R10 halt held", {31'b0, halt}, 32'h1);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    check("R10 wake releases halt", {31'b0, halt}, 32'h0);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 6'h08; wake = 1'b1;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0; wake = 1'b0;
    check("R10 pause beats wake", {31'b0, halt}, 32'h1);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    check("R10 second wake", {31'b0, halt}, 32'h0);
  endtask

  task automatic t_leave_boot();
    reg_wr(6'h20, 32'h0);
    xl("R6 flat after clear write", 32'h0000_0010, 32'h0000_0010);
    xl("R2 flat in window 1", 32'h0001_0000, 32'h0001_0000);
    reg_wr(6'h20, 32'h1);
    reg_wr(6'h30, 32'h1);
    reg_wr(6'h00, 32'h1);
    xl("R6 no register reselects boot", 32'h0000_0010, 32'h0000_0010);
  endtask

  task automatic t_strap();
    do_reset(1'b0);
    xl("R5 strap 0 gives flat map", 32'h0000_0010, 32'h0000_0010);
    do_reset(1'b1);
    xl("R5 strap 1 gives boot map", 32'h0000_0010, 32'h0400_0010);
  endtask

  initial begin
    win_en        = 3'b011;
    win_start[0]  = 32'h0000_0000; win_end[0] = 32'h0000_FFFF; win_target[0] = 32'h0400_0000;
    win_start[1]  = 32'h0000_8000; win_end[1] = 32'h0001_7FFF; win_target[1] = 32'h0800_0000;
    win_start[2]  = 32'h1000_0000; win_end[2] = 32'h1000_00FF; win_target[2] = 32'h3000_0000;
    t_reset_state();
    t_translate();
    t_por_clear();
    t_undefined();
    t_halt();
    t_leave_boot();
    t_strap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule